// File: doc/BRIEF.md
# Signed-Digit Serial Multiply-Accumulate Element

This element computes a 16-lane dot product between activations that arrive serially and weights that are held in parallel. Each activation is delivered one radix-2 signed digit per cycle, with the most significant digit first. Each weight is a 16-bit two's-complement word on a wide parallel bus. In every cycle that carries a digit, the element does three things:
- each lane turns its digit and weight into a signed-digit partial product,
- a tree of carry-free adders reduces the sixteen partial products to one redundant partial sum,
- the accumulator doubles its residual and adds that sum.

After sixteen digits the element raises a one-cycle done pulse. The 36-digit result is then presented in redundant form, as a positive bit vector and a negative bit vector. A separate converter downstream turns it into binary.

No stage contains a carry chain that runs the full width of a word. The critical path therefore depends on the number of adder levels, not on the word width. Digit slots may be stalled by holding the valid input low. A start pulse aborts the loop in progress. A new loop begins on its own after every done pulse.

Top module: `sd_serial_mac`

## Requirements
- R1: A digit is a pair of bits (positive bit, negative bit) worth positive + negative − 1. The pair (1,1) means +1, the pair (0,0) means −1, and both (1,0) and (0,1) mean 0. Any of these redundant encodings of an activation value gives the same result.
- R2: Lane i takes its weight from `wgt[16i+15:16i]` as two's complement. Its partial product is +W for a +1 digit, −W for a −1 digit and 0 for a 0 digit.
- R3: Every loop starts from a zero residual. This applies to the first digit after reset, after a done pulse, and to a digit presented together with `start`.
- R4: For each later digit of a loop, the new residual equals twice the old residual plus the sum of the sixteen partial products. The first digit of a loop is the most significant, so the result equals the sum over lanes of W·A.
- R5: `done` is high for exactly one cycle. It rises in the cycle after the sixteenth valid digit of a loop is clocked in, and at no other time.
- R6: The result value is (`res_pos` + `res_neg` + 1) mod 2^36, read as 36-bit two's complement. A negative bit of 1 stands for 0 and a negative bit of 0 stands for −1. The outputs change only when `done` rises and hold their value between done pulses.
- R7: A cycle with `dig_valid` low consumes no digit, so stall cycles leave the result and the timing of `done`, counted in valid digits, unchanged.
- R8: `start` with `dig_valid` low clears the residual and the digit count, which aborts the loop. `start` with `dig_valid` high makes that digit the first of a new loop.
- R9: A synchronous active-low reset sets `done` low, `res_pos` to all zeros, `res_neg` to all ones (value 0) and the digit count to zero.
- R10: The result is exact at the extremes. All weights at −32768 with every digit −1 gives +34359214080. The same weights with every digit +1 gives −34359214080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the residual and the digit count; aborts the loop in progress |
| dig_valid | input | 1 | One activation digit per lane is present this cycle |
| act_pos | input | 16 | Positive bit of each lane's current digit |
| act_neg | input | 16 | Negative bit of each lane's current digit |
| wgt | input | 256 | Sixteen 16-bit two's-complement weights, lane i at bits 16i+15:16i |
| done | output | 1 | One-cycle pulse when a new result is presented |
| res_pos | output | 36 | Positive bit vector of the redundant result |
| res_neg | output | 36 | Negative bit vector of the redundant result |

## Verification
The assertions run on every cycle and guard the following behaviour:
- the accumulator recurrence: the residual's binary value after a continuing digit equals twice the old value plus the partial sum, computed with an ordinary binary subtraction that is independent of the signed-digit adders,
- the zero-residual start of a loop and the clearing done by `start`,
- that `done` follows a valid digit and never lasts two cycles,
- that the result holds between pulses.

Only the bench's scenarios can show that the full dot product is correct against an integer model. The scenarios cover randomly chosen redundant encodings of each activation, stalls, aborted loops, back-to-back loops and the extreme magnitudes.

// File: rtl/sdmac_pkg.sv
// Package sdmac_pkg
// Holds the default geometry of the signed-digit MAC element, the code
// values of a digit (positive bit, negative bit) and the rule that sizes
// the accumulator so that a full loop cannot overflow.
package sdmac_pkg;

    localparam int DEF_LANES  = 16;
    localparam int DEF_WBITS  = 16;
    localparam int DEF_DIGITS = 16;

    // Digit codes as {positive bit, negative bit}.
    localparam logic [1:0] DIG_PLUS  = 2'b11;
    localparam logic [1:0] DIG_MINUS = 2'b00;

    // Width in digits that holds lanes * weight * full-length activation.
    function automatic int acc_width(input int lanes, input int wbits, input int digits);
        return wbits + digits + $clog2(lanes);
    endfunction

endpackage

// File: rtl/sdmac_add.sv
// Module sdmac_add
// Carry-free adder for two signed-digit vectors held as plus/minus bit
// planes (value = plus - minus, modulo 2^W). The adder has two rows of
// full adders, and every digit position sees a fixed logic depth whatever
// the width. Assumes the caller sized W so that the true sum fits.
module sdmac_add #(
    parameter int W = 36
) (
    input  logic [W-1:0] x_pl,
    input  logic [W-1:0] x_mi,
    input  logic [W-1:0] y_pl,
    input  logic [W-1:0] y_mi,
    output logic [W-1:0] z_pl,
    output logic [W-1:0] z_mi
);

    logic [W-1:0] s1;
    logic [W-2:0] c1;
    logic [W-1:0] t_pl;
    logic [W-1:0] s2;
    logic [W-2:0] c2;

    // Row 1: x_pl + y_pl - x_mi = 2*c1 - ~s1, using a full adder on (xp, yp, ~xm).
    always_comb begin
        s1   = x_pl ^ y_pl ^ ~x_mi;
        c1   = (x_pl[W-2:0] & y_pl[W-2:0]) | (x_pl[W-2:0] & ~x_mi[W-2:0])
             | (y_pl[W-2:0] & ~x_mi[W-2:0]);
        t_pl = {c1, 1'b0};
    end

    // Row 2: t_pl - ~s1 - y_mi = s2 - 2*~c2, using a full adder on (t_pl, s1, ~ym).
    always_comb begin
        s2   = t_pl ^ s1 ^ ~y_mi;
        c2   = (t_pl[W-2:0] & s1[W-2:0]) | (t_pl[W-2:0] & ~y_mi[W-2:0])
             | (s1[W-2:0] & ~y_mi[W-2:0]);
        z_pl = s2;
        z_mi = {~c2, 1'b0};
    end

endmodule

// File: rtl/sdmac_ppgen.sv
// Module sdmac_ppgen
// Forms one signed-digit partial product per lane. The weight is
// sign-extended to the accumulator width and routed into the plus plane
// (digit +1), the minus plane (digit -1) or neither (digit 0). No negation
// or increment is needed. Assumes ACCW >= WBITS.
module sdmac_ppgen
    import sdmac_pkg::*;
#(
    parameter int LANES = 16,
    parameter int WBITS = 16,
    parameter int ACCW  = 36
) (
    input  logic [LANES-1:0]       act_pos,
    input  logic [LANES-1:0]       act_neg,
    input  logic [LANES*WBITS-1:0] wgt,
    output logic [LANES*ACCW-1:0]  pp_pl,
    output logic [LANES*ACCW-1:0]  pp_mi
);

    localparam int EXT = ACCW - WBITS;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WBITS-1:0] w_raw;
        logic [ACCW-1:0]  w_ext;
        logic [1:0]       code;

        // Sign-extend this lane's weight and select the plane from its digit.
        always_comb begin
            w_raw = wgt[g*WBITS +: WBITS];
            w_ext = {{EXT{w_raw[WBITS-1]}}, w_raw};
            code  = {act_pos[g], act_neg[g]};
            pp_pl[g*ACCW +: ACCW] = (code == DIG_PLUS)  ? w_ext : '0;
            pp_mi[g*ACCW +: ACCW] = (code == DIG_MINUS) ? w_ext : '0;
        end
    end

endmodule

// File: rtl/sdmac_tree.sv
// Module sdmac_tree
// Reduces LANES signed-digit partial products to one partial sum with a
// heap-ordered tree of carry-free adders. Node 0 is the root, node i has
// children 2i+1 and 2i+2, and the leaves are nodes LANES-1 and up. Works
// for any LANES >= 2; the depth is ceil(log2(LANES)) adder levels.
module sdmac_tree #(
    parameter int LANES = 16,
    parameter int ACCW  = 36
) (
    input  logic [LANES*ACCW-1:0] pp_pl,
    input  logic [LANES*ACCW-1:0] pp_mi,
    output logic [ACCW-1:0]       ps_pl,
    output logic [ACCW-1:0]       ps_mi
);

    localparam int NODES = 2 * LANES - 1;

    logic [ACCW-1:0] nd_pl [NODES];
    logic [ACCW-1:0] nd_mi [NODES];

    for (genvar g = 0; g < LANES; g++) begin : g_leaf
        // Place partial product g at its leaf node.
        assign nd_pl[LANES-1+g] = pp_pl[g*ACCW +: ACCW];
        assign nd_mi[LANES-1+g] = pp_mi[g*ACCW +: ACCW];
    end

    for (genvar g = 0; g < LANES - 1; g++) begin : g_node
        sdmac_add #(.W(ACCW)) u_add (
            .x_pl (nd_pl[2*g+1]),
            .x_mi (nd_mi[2*g+1]),
            .y_pl (nd_pl[2*g+2]),
            .y_mi (nd_mi[2*g+2]),
            .z_pl (nd_pl[g]),
            .z_mi (nd_mi[g])
        );
    end

    // The root carries the compressed partial sum.
    assign ps_pl = nd_pl[0];
    assign ps_mi = nd_mi[0];

endmodule

// File: rtl/sdmac_acc.sv
// Module sdmac_acc
// Serial accumulator and loop control. On each valid digit it doubles the
// residual and adds the partial sum. The residual is taken as zero on the
// first digit of a loop (count zero, or start). The result register is
// loaded and done pulsed on the DIGITS-th digit. Values are plus/minus
// planes. Synchronous active-low reset.
module sdmac_acc #(
    parameter int DIGITS = 16,
    parameter int ACCW   = 36
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dig_valid,
    input  logic [ACCW-1:0] ps_pl,
    input  logic [ACCW-1:0] ps_mi,
    output logic            done,
    output logic [ACCW-1:0] res_pl,
    output logic [ACCW-1:0] res_mi
);

    localparam int CW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    logic [ACCW-1:0] rs_pl, rs_mi;
    logic [ACCW-1:0] base_pl, base_mi;
    logic [ACCW-1:0] sum_pl, sum_mi;
    logic [CW-1:0]   cnt;
    logic            first_dig;
    logic            last_dig;

    // Pick a zero or the doubled residual as the addend for this digit.
    always_comb begin
        first_dig = start | (cnt == '0);
        last_dig  = (cnt == CW'(DIGITS - 1)) & ~start;
        base_pl   = first_dig ? '0 : {rs_pl[ACCW-2:0], 1'b0};
        base_mi   = first_dig ? '0 : {rs_mi[ACCW-2:0], 1'b0};
    end

    sdmac_add #(.W(ACCW)) u_acc_add (
        .x_pl (base_pl),
        .x_mi (base_mi),
        .y_pl (ps_pl),
        .y_mi (ps_mi),
        .z_pl (sum_pl),
        .z_mi (sum_mi)
    );

    // Advance the residual, digit count and result on valid digits or start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_pl  <= '0;
            rs_mi  <= '0;
            cnt    <= '0;
            done   <= 1'b0;
            res_pl <= '0;
            res_mi <= '0;
        end else begin
            done <= 1'b0;
            if (dig_valid) begin
                rs_pl <= sum_pl;
                rs_mi <= sum_mi;
                if (start) begin
                    cnt <= CW'(1 % DIGITS);
                end else if (last_dig) begin
                    cnt    <= '0;
                    done   <= 1'b1;
                    res_pl <= sum_pl;
                    res_mi <= sum_mi;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else if (start) begin
                rs_pl <= '0;
                rs_mi <= '0;
                cnt   <= '0;
            end
        end
    end

    // Binary views used only by the checks below.
    logic [ACCW-1:0] rs_val, ps_val;
    assign rs_val = rs_pl - rs_mi;
    assign ps_val = ps_pl - ps_mi;

    // R4: a continuing digit doubles the residual and adds the partial sum.
    p_accum_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && !start && cnt != '0) |=> rs_val == (($past(rs_val) << 1) + $past(ps_val)));

    // R3: the first digit of a loop starts from a zero residual.
    p_first_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_valid && (start || cnt == '0)) |=> rs_val == $past(ps_val));

    // R8: start without a digit clears the residual.
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dig_valid) |=> rs_val == '0);

endmodule

// File: rtl/sd_serial_mac.sv
// Module sd_serial_mac
// Top of the signed-digit serial MAC element: partial product generator,
// compression tree and serial accumulator. The result leaves with the
// negative plane in the port encoding (bit 1 means 0, bit 0 means -1),
// i.e. the inverted minus plane. Assumes weights are stable while their
// digits are presented.
module sd_serial_mac
    import sdmac_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int WBITS  = DEF_WBITS,
    parameter int DIGITS = DEF_DIGITS,
    localparam int ACCW  = acc_width(LANES, WBITS, DIGITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   dig_valid,
    input  logic [LANES-1:0]       act_pos,
    input  logic [LANES-1:0]       act_neg,
    input  logic [LANES*WBITS-1:0] wgt,
    output logic                   done,
    output logic [ACCW-1:0]        res_pos,
    output logic [ACCW-1:0]        res_neg
);

    logic [LANES*ACCW-1:0] pp_pl, pp_mi;
    logic [ACCW-1:0]       ps_pl, ps_mi;
    logic [ACCW-1:0]       r_pl, r_mi;

    sdmac_ppgen #(.LANES(LANES), .WBITS(WBITS), .ACCW(ACCW)) u_ppgen (
        .act_pos (act_pos),
        .act_neg (act_neg),
        .wgt     (wgt),
        .pp_pl   (pp_pl),
        .pp_mi   (pp_mi)
    );

    sdmac_tree #(.LANES(LANES), .ACCW(ACCW)) u_tree (
        .pp_pl (pp_pl),
        .pp_mi (pp_mi),
        .ps_pl (ps_pl),
        .ps_mi (ps_mi)
    );

    sdmac_acc #(.DIGITS(DIGITS), .ACCW(ACCW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dig_valid (dig_valid),
        .ps_pl     (ps_pl),
        .ps_mi     (ps_mi),
        .done      (done),
        .res_pl    (r_pl),
        .res_mi    (r_mi)
    );

    // Map the internal minus plane onto the port's negative-bit encoding.
    assign res_pos = r_pl;
    assign res_neg = ~r_mi;

    // R5: done only follows a clocked-in digit.
    p_done_needs_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(dig_valid));

    // R5: done is a single-cycle pulse.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the result holds between done pulses.
    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> ($stable(res_pos) && $stable(res_neg)));

endmodule

// File: tb/sd_serial_mac_tb.sv
`timescale 1ns/1ps
module sd_serial_mac_tb;

    localparam int L  = 16;
    localparam int WB = 16;
    localparam int D  = 16;
    localparam int AW = 36;
    localparam int NROW = 9;

    // Table: every lane gets the same weight and activation; expected = 16*w*a.
    localparam int     T_W [NROW] = '{1, -1, 32767, -32768, -32768, 0, 100, -5, -3};
    localparam int     T_A [NROW] = '{1, 1, 32767, -65535, 65535, 12345, -7, 0, -21};
    localparam longint T_E [NROW] = '{64'sd16, -64'sd16, 64'sd17178820624, 64'sd34359214080,
                                      -64'sd34359214080, 64'sd0, -64'sd11200, 64'sd0, 64'sd1008};
    localparam string  T_R [NROW] = '{"R1", "R2", "R4", "R10", "R10", "R2", "R1", "R2", "R1"};

    logic            clk = 1'b0;
    logic            rst_n, start, dig_valid;
    logic [L-1:0]    act_pos, act_neg;
    logic [L*WB-1:0] wgt;
    logic            done;
    logic [AW-1:0]   res_pos, res_neg;

    int n_chk = 0;
    int n_bad = 0;

    int              w_v [L];
    int              a_v [L];
    logic [D-1:0]    dp_v [L];
    logic [D-1:0]    dn_v [L];

    always #2 clk = ~clk;

    sd_serial_mac u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .dig_valid (dig_valid),
        .act_pos (act_pos), .act_neg (act_neg), .wgt (wgt),
        .done (done), .res_pos (res_pos), .res_neg (res_neg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint to_val(input logic [AW-1:0] p, input logic [AW-1:0] n);
        logic [AW-1:0] s;
        s = p + n + AW'(1);
        return longint'($signed(s));
    endfunction

    function automatic longint model();
        longint acc = 0;
        for (int i = 0; i < L; i++) acc += longint'(w_v[i]) * longint'(a_v[i]);
        return acc;
    endfunction

    // Encode every lane's activation with randomly chosen redundant digits.
    task automatic encode_all();
        for (int i = 0; i < L; i++) begin
            int r = a_v[i];
            for (int k = 0; k < D; k++) begin
                int d = 0;
                if (r % 2 != 0) begin
                    int lim = (1 << (D - 1 - k)) - 1;
                    int nr;
                    d  = ($urandom % 2 == 0) ? 1 : -1;
                    nr = (r - d) / 2;
                    if (nr > lim || nr < -lim) d = -d;
                end
                r = (r - d) / 2;
                if (d == 1)       begin dp_v[i][k] = 1'b1; dn_v[i][k] = 1'b1; end
                else if (d == -1) begin dp_v[i][k] = 1'b0; dn_v[i][k] = 1'b0; end
                else begin
                    dp_v[i][k] = 1'($urandom % 2);
                    dn_v[i][k] = ~dp_v[i][k];
                end
            end
            wgt[i*WB +: WB] = WB'(w_v[i]);
        end
    endtask

    task automatic drive_digit(input int j);
        for (int i = 0; i < L; i++) begin
            act_pos[i] = dp_v[i][D-1-j];
            act_neg[i] = dn_v[i][D-1-j];
        end
    endtask

    task automatic run_loop(input string req, input bit stalls, input bit start_first,
                            input bit idle_after, output longint got);
        longint exp;
        bit early = 0;
        exp = model();
        encode_all();
        for (int j = 0; j < D; j++) begin
            if (stalls && ($urandom % 3 == 0)) begin
                dig_valid = 0; start = 0;
                @(negedge clk);
                if (done) early = 1;
            end
            dig_valid = 1;
            start = start_first && (j == 0);
            drive_digit(j);
            @(negedge clk);
            if (j < D - 1 && done) early = 1;
        end
        check(!early, "R5", "no done before 16th digit", longint'(early), 0);
        check(done == 1'b1, "R5", "done after 16th digit", longint'(done), 1);
        got = to_val(res_pos, res_neg);
        check(got == exp, req, "dot product", got, exp);
        if (idle_after) begin
            dig_valid = 0; start = 0;
            @(negedge clk);
            check(done == 1'b0, "R5", "done one cycle wide", longint'(done), 0);
        end
    endtask

    task automatic rand_vec();
        for (int i = 0; i < L; i++) begin
            w_v[i] = int'($urandom % 65536) - 32768;
            a_v[i] = int'($urandom % 131071) - 65535;
        end
    endtask

    task automatic junk_digits(input int n);
        rand_vec();
        encode_all();
        for (int j = 0; j < n; j++) begin
            dig_valid = 1; start = 0;
            drive_digit(j);
            @(negedge clk);
            check(done == 1'b0, "R8", "no done on partial loop", longint'(done), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint got, held;
        rst_n = 0; start = 0; dig_valid = 0; act_pos = '0; act_neg = '0; wgt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state.
        check(done == 1'b0, "R9", "done after reset", longint'(done), 0);
        check(res_pos == '0 && res_neg == '1, "R9", "result planes after reset",
              to_val(res_pos, res_neg), 0);

        // Table walk: R1 R2 R4 R10.
        for (int r = 0; r < NROW; r++) begin
            for (int i = 0; i < L; i++) begin w_v[i] = T_W[r]; a_v[i] = T_A[r]; end
            run_loop(T_R[r], 0, 0, 1, got);
            check(got == T_E[r], T_R[r], "table result", got, T_E[r]);
        end

        // R1: same activations, fresh random redundant encodings.
        for (int n = 0; n < 6; n++) begin
            rand_vec();
            run_loop("R1", 0, 0, 1, got);
        end

        // R7: random stalls between digits.
        for (int n = 0; n < 8; n++) begin
            rand_vec();
            run_loop("R7", 1, 0, 1, got);
        end

        // R3: back-to-back loops with no idle cycle.
        for (int n = 0; n < 4; n++) begin
            rand_vec();
            run_loop("R3", 0, 0, 0, got);
        end
        dig_valid = 0;
        @(negedge clk);

        // R6: result holds while idle and during a later partial loop.
        rand_vec();
        run_loop("R6", 0, 0, 1, held);
        repeat (6) @(negedge clk);
        check(to_val(res_pos, res_neg) == held, "R6", "hold while idle",
              to_val(res_pos, res_neg), held);
        junk_digits(8);
        check(to_val(res_pos, res_neg) == held, "R6", "hold during loop",
              to_val(res_pos, res_neg), held);

        // R8: start without a digit aborts; the next loop is clean.
        dig_valid = 0; start = 1;
        @(negedge clk);
        start = 0;
        check(done == 1'b0, "R8", "no done on abort", longint'(done), 0);
        rand_vec();
        run_loop("R8", 0, 0, 1, got);

        // R8: start with the first digit of a new loop after a partial one.
        junk_digits(5);
        rand_vec();
        run_loop("R8", 1, 1, 1, got);

        // R9: reset in the middle of a loop.
        junk_digits(5);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; dig_valid = 0;
        @(negedge clk);
        check(done == 1'b0 && res_pos == '0 && res_neg == '1, "R9", "mid-loop reset",
              to_val(res_pos, res_neg), 0);
        rand_vec();
        run_loop("R9", 0, 0, 1, got);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule